// File: doc/BRIEF.md
# Selectable Slot Test-Pattern Generator

This block feeds the four serial inputs of a time-slot switch with framed test traffic. Each line carries 32 slots of 8 bits per frame. The block takes its bit-enable pulse and its slot and bit indices from the timing chain that also clocks the switch, so generated slot n lines up with slot n at the switch input. By default every slot on every line is zero.

A 7-bit target value chooses one line and one slot. While a generate push-button is held, that single position carries the alternating byte `10101010`. All other positions stay zero. The button input is synchronised and debounced. Its settled state is taken into account only at a slot boundary, so a slot is never partly patterned. The target value is latched at the same boundary. The line named by the latched target is also copied to a single monitor pin, where it can be probed.

Top module: `tpg_top`

## Requirements
- R1: During reset and right after it, all four lines and the monitor pin are low.
- R2: While the debounced button is released, every slot of every line carries 0x00.
- R3: While the debounced button is pressed, the slot whose index equals `target_i[4:0]` on the line whose number equals `target_i[6:5]` carries 0xAA. Every other slot on every line carries 0x00, so at most one line is high at any time.
- R4: Each byte is sent MSB first. A slot starts at the bit-enable pulse with `bit_idx_i == 0`, and the bit at index b goes out at the pulse with `bit_idx_i == b`. A line changes only in the clock after a bit-enable pulse.
- R5: The button passes through two synchroniser flops. The debounced level takes the synchronised value only after that value has differed from it for `DEB_CYCLES` consecutive clocks, so a shorter glitch has no effect.
- R6: The debounced button is sampled only at a slot boundary (bit-enable with `bit_idx_i == 0`). A press or release between boundaries leaves the slot in progress unchanged.
- R7: The target value is latched only at a slot boundary. A change in the middle of a slot has no effect until the next slot.
- R8: `mon_o` equals the line whose number was latched at the most recent slot boundary (line 0 before the first boundary).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_en_i | input | 1 | One-clock pulse per serial bit, shared with the switch |
| slot_idx_i | input | 5 | Current slot index from the shared timing chain |
| bit_idx_i | input | 3 | Current bit index within the slot, 0 is the MSB |
| target_i | input | 7 | [6:5] line number, [4:0] slot number |
| gen_btn_i | input | 1 | Raw generate push-button, high when pressed |
| line_o | output | 4 | Serial streams, one per switch input |
| mon_o | output | 1 | Copy of the currently selected line |

## Verification
Two events can fall in the same clock: the debounced button may change on the very edge that is a slot boundary, and the target may change on that edge as well. The bench sweeps the press and release instant across many offsets around several boundaries, and it also moves the target exactly on boundary edges and in the middle of slots. A per-clock behavioural model decides which slot takes the pattern. At a boundary the model uses the button level that held before the edge, and every clock the line and monitor outputs are compared with the model.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
    localparam int LINE_N  = 4;
    localparam int SLOT_N  = 32;
    localparam int BYTE_W  = 8;
    localparam logic [BYTE_W-1:0] TEST_BYTE = 8'b1010_1010;
endpackage

// File: rtl/tpg_sync_debounce.sv
module tpg_sync_debounce #(
    parameter int DEB_CYCLES = 50000,
    localparam int CNT_W = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic raw_i,
    output logic sync_o,
    output logic level_o
);
    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             level;
        logic [CNT_W-1:0] cnt;
    } deb_t;

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

    deb_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw_i;
        st_d.s2 = st_q.s1;
        if (st_q.s2 == st_q.level) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CNT_LAST) begin
            st_d.level = st_q.s2;
            st_d.cnt   = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sync_o  = st_q.s2;
    assign level_o = st_q.level;
endmodule

// File: rtl/tpg_line_shifter.sv
module tpg_line_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bit_en_i,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              ser_o
);
    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic              ser;
    } shf_t;

    shf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.ser = byte_i[BYTE_W-1];
            st_d.sh  = byte_i << 1;
        end else if (bit_en_i) begin
            st_d.ser = st_q.sh[BYTE_W-1];
            st_d.sh  = st_q.sh << 1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ser_o = st_q.ser;
endmodule

// File: rtl/tpg_top.sv
module tpg_top #(
    parameter int LINES      = tpg_pkg::LINE_N,
    parameter int SLOTS      = tpg_pkg::SLOT_N,
    parameter int BYTE_W     = tpg_pkg::BYTE_W,
    parameter int DEB_CYCLES = 50000,
    parameter logic [BYTE_W-1:0] PATTERN = tpg_pkg::TEST_BYTE
) (
    input  logic                                        clk_i,
    input  logic                                        rst_ni,
    input  logic                                        bit_en_i,
    input  logic [$clog2(SLOTS)-1:0]                    slot_idx_i,
    input  logic [$clog2(BYTE_W)-1:0]                   bit_idx_i,
    input  logic [$clog2(LINES)+$clog2(SLOTS)-1:0]      target_i,
    input  logic                                        gen_btn_i,
    output logic [LINES-1:0]                            line_o,
    output logic                                        mon_o
);
    localparam int LINE_W = $clog2(LINES);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int BIT_W  = $clog2(BYTE_W);

    typedef struct packed {
        logic [LINE_W-1:0] sel_line;
        logic              act;
    } top_t;

    top_t st_d, st_q;

    logic              btn_sync;
    logic              btn_db;
    logic              boundary;
    logic [LINE_W-1:0] tgt_line;
    logic [SLOT_W-1:0] tgt_slot;
    logic              slot_hit;

    tpg_sync_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .raw_i   (gen_btn_i),
        .sync_o  (btn_sync),
        .level_o (btn_db)
    );

    assign boundary = bit_en_i && (bit_idx_i == '0);
    assign tgt_line = target_i[SLOT_W +: LINE_W];
    assign tgt_slot = target_i[SLOT_W-1:0];
    assign slot_hit = btn_db && (tgt_slot == slot_idx_i);

    always_comb begin
        st_d = st_q;
        if (boundary) begin
            st_d.sel_line = tgt_line;
            st_d.act      = slot_hit;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    for (genvar k = 0; k < LINES; k++) begin : g_line
        logic [BYTE_W-1:0] byte_k;
        assign byte_k = (slot_hit && (tgt_line == LINE_W'(k))) ? PATTERN : '0;
        tpg_line_shifter #(.BYTE_W(BYTE_W)) u_shf (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .bit_en_i (bit_en_i),
            .load_i   (boundary),
            .byte_i   (byte_k),
            .ser_o    (line_o[k])
        );
    end

    assign mon_o = line_o[st_q.sel_line];
endmodule

module tpg_checker #(
    parameter int LINES = 4,
    parameter int BIT_W = 3
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             bit_en_i,
    input logic [BIT_W-1:0] bit_idx_i,
    input logic [LINES-1:0] line_o,
    input logic             btn_sync,
    input logic             btn_db,
    input logic             act_q
);
    assert_one_line_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(line_o));

    assert_change_on_bit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bit_en_i |=> $stable(line_o));

    assert_rise_follows_sync_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(btn_db) |-> $past(btn_sync));

    assert_fall_follows_sync_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(btn_db) |-> !$past(btn_sync));

    assert_gate_at_boundary_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bit_en_i && bit_idx_i == '0) |=> $stable(act_q));
endmodule

bind tpg_top tpg_checker #(.LINES(LINES), .BIT_W(BIT_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_en_i  (bit_en_i),
    .bit_idx_i (bit_idx_i),
    .line_o    (line_o),
    .btn_sync  (btn_sync),
    .btn_db    (btn_db),
    .act_q     (st_q.act)
);

// File: tb/tpg_top_tb_top.sv
`timescale 1ns/1ps
module tpg_top_tb_top;
    localparam int DEB = 8;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic [4:0] slot_idx = '0;
    logic [2:0] bit_idx = '0;
    logic [6:0] target = '0;
    logic       btn = 1'b0;
    logic [3:0] line;
    logic       mon;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    tpg_top #(.DEB_CYCLES(DEB)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .slot_idx_i(slot_idx),
        .bit_idx_i(bit_idx), .target_i(target), .gen_btn_i(btn),
        .line_o(line), .mon_o(mon)
    );

    // behavioural reference
    int m_s1, m_s2, m_db, m_cnt, m_lat;
    logic [7:0] m_byte [4];
    logic [3:0] m_line;
    int div_cnt = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_db = 0; m_cnt = 0; m_lat = 0; m_line = '0;
            for (int k = 0; k < 4; k++) m_byte[k] = 8'h00;
        end else begin
            if (bit_en && bit_idx == 0) begin
                for (int k = 0; k < 4; k++)
                    m_byte[k] = (m_db == 1 && k == int'(target[6:5]) && slot_idx == target[4:0]) ? 8'hAA : 8'h00;
                m_lat = int'(target[6:5]);
            end
            if (bit_en)
                for (int k = 0; k < 4; k++) m_line[k] = m_byte[k][7 - int'(bit_idx)];
            if (m_s2 == m_db) m_cnt = 0;
            else if (m_cnt == DEB - 1) begin m_db = m_s2; m_cnt = 0; end
            else m_cnt = m_cnt + 1;
            m_s2 = m_s1;
            m_s1 = int'(btn);
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // per-clock compare and timing drive at negedge
    int rise_cnt [4];
    logic [3:0] prev_line = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            check(line == m_line, cur_req, "line_o", int'(line), int'(m_line));
            check(mon == m_line[m_lat], "R8", "mon_o", int'(mon), int'(m_line[m_lat]));
            for (int k = 0; k < 4; k++) if (line[k] && !prev_line[k]) rise_cnt[k]++;
            prev_line = line;
            if (bit_en) begin
                if (bit_idx == 3'd7) slot_idx <= slot_idx + 1'b1;
                bit_idx <= bit_idx + 1'b1;
            end
            div_cnt = (div_cnt + 1) % DIV;
            bit_en <= (div_cnt == 0);
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_rises();
        for (int k = 0; k < 4; k++) rise_cnt[k] = 0;
    endtask

    // wait until the next slot boundary pulse is about to be applied to slot s
    task automatic wait_slot(input int s);
        while (!(bit_en && bit_idx == 0 && int'(slot_idx) == s)) @(posedge clk);
        @(negedge clk);
    endtask

    localparam int FRAME = 32 * 8 * DIV;

    initial begin
        for (int k = 0; k < 4; k++) rise_cnt[k] = 0;
        wait_clk(3);
        check(line == 4'b0 && mon == 1'b0, "R1", "outputs in reset", int'({mon, line}), 0);
        rst_n = 1'b1;
        wait_clk(2);
        check(line == 4'b0, "R1", "outputs after reset", int'(line), 0);

        // idle: target set, button released
        cur_req = "R2";
        target = {2'd2, 5'd5};
        clear_rises();
        wait_clk(2 * FRAME);
        check(rise_cnt[0] + rise_cnt[1] + rise_cnt[2] + rise_cnt[3] == 0, "R2", "idle rises", rise_cnt[2], 0);

        // press and hold: line 2 slot 5
        cur_req = "R3";
        btn = 1'b1;
        wait_slot(0);
        clear_rises();
        wait_clk(FRAME);
        check(rise_cnt[2] == 4, "R3", "pattern rises on line 2", rise_cnt[2], 4);
        check(rise_cnt[0] + rise_cnt[1] + rise_cnt[3] == 0, "R3", "other lines", rise_cnt[0] + rise_cnt[1] + rise_cnt[3], 0);

        // MSB first check on the target slot: first bit is 1, second is 0
        cur_req = "R4";
        wait_slot(5);
        wait_clk(2);
        check(line[2] == 1'b1, "R4", "bit 7 of slot", int'(line[2]), 1);
        wait_clk(DIV);
        check(line[2] == 1'b0, "R4", "bit 6 of slot", int'(line[2]), 0);

        // glitch release shorter than debounce window
        cur_req = "R5";
        wait_slot(20);
        btn = 1'b0; wait_clk(DEB - 3); btn = 1'b1;
        wait_slot(0);
        clear_rises();
        wait_clk(FRAME);
        check(rise_cnt[2] == 4, "R5", "glitch ignored", rise_cnt[2], 4);

        // corner target: line 3 slot 31, then slot 0
        cur_req = "R3";
        target = {2'd3, 5'd31};
        wait_clk(2 * FRAME);
        target = {2'd0, 5'd0};
        wait_clk(2 * FRAME);

        // target change mid-slot
        cur_req = "R7";
        target = {2'd1, 5'd9};
        wait_slot(9);
        wait_clk(DIV * 3);
        target = {2'd3, 5'd9};
        wait_clk(DIV * 2);
        check(line[3] == 1'b0, "R7", "mid-slot target change ignored", int'(line[3]), 0);
        wait_clk(FRAME);

        // sweep button edges across slot boundaries
        cur_req = "R6";
        target = {2'd1, 5'd3};
        for (int off = 0; off < 3 * 8 * DIV; off++) begin
            wait_slot(1);
            wait_clk(off);
            btn = ~btn;
            wait_clk(16 * 8 * DIV);
        end

        // target changes exactly on boundary edges
        cur_req = "R7";
        btn = 1'b1;
        for (int s = 0; s < 8; s++) begin
            while (!(bit_en && bit_idx == 7)) @(negedge clk);
            target = {2'(s % 4), 5'(4 + s)};
            wait_clk(DIV * 4);
        end
        wait_clk(FRAME);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule